// File: doc/BRIEF.md
# Bus Transaction Initiator with Dual-Cycle Addressing

This block is the initiating side of a parallel bus on which address and data share one set of 32 wires. The local logic hands it a request: a 64-bit byte address, a 4-bit command, a read/write direction and a beat count. The block raises a request toward the bus arbiter and waits for a grant. It then drives the address phase and runs a burst of data phases, all in the same direction. While a write burst runs, the local side supplies each beat's data word and byte-enable mask, indexed by the running beat count.

When the upper 32 address bits are all zero, the address goes out in a single cycle together with the command. Otherwise the block spends two address cycles. The first carries the lower word with a reserved command value that announces the long form. The second carries the upper word with the real command. The target may hold a beat off with wait states, and the local side can do the same through a hold input. The target may also cut the burst short at any beat. If no target claims the cycle soon after the address phase, the block gives up. When the transaction ends, the block reports the number of beats moved and whether it was stopped early or abandoned unclaimed.

Top module: `busx_initiator`

## Requirements
- R1: `frame_o` stays low while the block requests the bus. The first address cycle starts only in the clock after a clock at which `bus_gnt` was sampled high.
- R2: If request address bits [63:32] are all zero, the address phase lasts one cycle, with `ad_o` = address[31:0] and `cbe_o` = the request command. The first data phase follows in the next cycle.
- R3: If request address bits [63:32] are non-zero, the first address cycle carries address[31:0] with `cbe_o` = 4'b1101. The second carries address[63:32] with the request command. Both words come from values captured when the request was accepted.
- R4: In a write data phase, `ad_oe` is high and `ad_o`/`cbe_o` carry `beat_data`/`beat_mask` for the beat numbered by `beat_count`. At the target, only bytes whose mask bit is 1 (bit i covers `ad_o[8i+7:8i]`) change. In a read data phase, `ad_oe` is low, and `rd_valid` pulses one clock after a completed beat, with `rd_data` equal to the `ad_i` value sampled on that beat.
- R5: A beat completes only at a clock where `irdy_o`, `trdy_i` and `devsel_i` are all high. During data phases, `irdy_o` equals the inverse of `loc_hold`.
- R6: A request with `req_beats_m1` = N moves N+1 beats and then ends. In the following cycle `frame_o` is low and `done` is high for exactly one clock, with `beat_count` holding the number of beats moved.
- R7: When `stop_i` and `devsel_i` are both high at a clock in a data phase, the transaction ends after that clock. A beat completing at that same clock is counted. `stopped_early` is set exactly when fewer beats than requested were moved.
- R8: If `devsel_i` stays low through the first 4 data-phase clocks, the transaction ends after the 4th, with `master_abort` high and zero beats moved.
- R9: `req_start` is ignored unless the block is idle. After `done`, the block returns to idle without raising `bus_req` again.
- R10: `frame_o` is high from the first address cycle through the last data phase and low otherwise, and `irdy_o` is high only while `frame_o` is high. After reset `bus_req`, `frame_o`, `irdy_o`, `ad_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Accept a new request (only when idle) |
| req_addr | input | 64 | Transaction start address |
| req_cmd | input | 4 | Transaction command code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats_m1 | input | BEAT_W | Number of data beats minus one |
| loc_hold | input | 1 | Local side inserts a wait state |
| beat_data | input | 32 | Write word for the current beat |
| beat_mask | input | 4 | Byte enables for the current beat |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| frame_o | output | 1 | Transaction in progress |
| irdy_o | output | 1 | Initiator ready for a data beat |
| ad_o | output | 32 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| cbe_o | output | 4 | Command in address cycles, byte enables in data cycles |
| ad_i | input | 32 | Read data from the bus |
| devsel_i | input | 1 | Target has claimed the transaction |
| trdy_i | input | 1 | Target ready for a data beat |
| stop_i | input | 1 | Target requests an end |
| beat_count | output | BEAT_W+1 | Beats completed in the current/last transaction |
| rd_valid | output | 1 | `rd_data` holds a newly read word |
| rd_data | output | 32 | Last word read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| stopped_early | output | 1 | Target ended the burst with beats left |
| master_abort | output | 1 | No target claimed the transaction |

## Verification
The critical coincidence is a target stop arriving at the same clock as a completed beat, including the case where that beat is the final one. A stop on the last beat must not be reported as early. A stop with data before the end must count the beat and flag early. A stop without data must not count it. The bench sweeps the stop position over every beat of a four-beat burst, both with and without a simultaneous ready. Independently of the design, it predicts the beat total and the early flag from that position. It also checks the byte-masked memory image the target model built. A second overlap, a local hold falling on the cycle where the target becomes ready, comes from hold and wait patterns that keep drifting against each other across the sweep.

// File: rtl/busx_pkg.sv
package busx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADR1,
    ST_ADR2,
    ST_DATA,
    ST_END
  } busx_state_e;

  // command value announcing a two-cycle (64-bit) address phase
  localparam logic [3:0] LONG_ADDR_CMD = 4'b1101;

endpackage

// File: rtl/busx_addr_phase.sv
module busx_addr_phase
  import busx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CBE_W  = DATA_W / 8
) (
  input  logic [2*DATA_W-1:0] addr,
  input  logic [CBE_W-1:0]    cmd,
  input  logic                hi_cycle,
  output logic                dual,
  output logic [DATA_W-1:0]   ad,
  output logic [CBE_W-1:0]    cbe
);

  // long form is used only when some upper address bit is set
  assign dual = |addr[2*DATA_W-1:DATA_W];

  always_comb begin
    ad  = hi_cycle ? addr[2*DATA_W-1:DATA_W] : addr[DATA_W-1:0];
    cbe = (dual && !hi_cycle) ? CBE_W'(LONG_ADDR_CMD) : cmd;
  end

endmodule

// File: rtl/busx_beat_track.sv
module busx_beat_track #(
  parameter int BEAT_W     = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic              xfer,
  input  logic              devsel,
  input  logic [BEAT_W-1:0] len_m1,
  output logic [BEAT_W:0]   count,
  output logic              beat_final,
  output logic              timeout
);

  localparam int              WC_W    = $clog2(ABORT_CLKS) + 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(ABORT_CLKS - 1);

  logic [BEAT_W:0] cnt_q, cnt_d;
  logic            claimed_q, claimed_d;
  logic [WC_W-1:0] wc_q, wc_d;
  logic            unclaimed;

  assign unclaimed  = active && !claimed_q && !devsel;
  assign beat_final = xfer && (cnt_q == {1'b0, len_m1});
  assign timeout    = unclaimed && (wc_q == WC_LAST);
  assign count      = cnt_q;

  always_comb begin
    cnt_d     = cnt_q;
    claimed_d = claimed_q;
    wc_d      = wc_q;
    if (clr) begin
      cnt_d     = '0;
      claimed_d = 1'b0;
      wc_d      = '0;
    end else begin
      if (xfer)               cnt_d     = cnt_q + 1'b1;
      if (active && devsel)   claimed_d = 1'b1;
      if (unclaimed && wc_q != WC_LAST) wc_d = wc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      claimed_q <= 1'b0;
      wc_q      <= '0;
    end else begin
      cnt_q     <= cnt_d;
      claimed_q <= claimed_d;
      wc_q      <= wc_d;
    end
  end

endmodule

// File: rtl/busx_seq.sv
module busx_seq
  import busx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        gnt,
  input  logic        dual,
  input  logic        finish,
  output busx_state_e state
);

  busx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)  state_d = ST_REQ;
      ST_REQ:  if (gnt)    state_d = ST_ADR1;
      ST_ADR1:             state_d = dual ? ST_ADR2 : ST_DATA;
      ST_ADR2:             state_d = ST_DATA;
      ST_DATA: if (finish) state_d = ST_END;
      ST_END:              state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/busx_initiator.sv
module busx_initiator
  import busx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_W     = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_start,
  input  logic [2*DATA_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0]   req_cmd,
  input  logic                  req_write,
  input  logic [BEAT_W-1:0]     req_beats_m1,
  input  logic                  loc_hold,
  input  logic [DATA_W-1:0]     beat_data,
  input  logic [DATA_W/8-1:0]   beat_mask,
  output logic                  bus_req,
  input  logic                  bus_gnt,
  output logic                  frame_o,
  output logic                  irdy_o,
  output logic [DATA_W-1:0]     ad_o,
  output logic                  ad_oe,
  output logic [DATA_W/8-1:0]   cbe_o,
  input  logic [DATA_W-1:0]     ad_i,
  input  logic                  devsel_i,
  input  logic                  trdy_i,
  input  logic                  stop_i,
  output logic [BEAT_W:0]       beat_count,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  done,
  output logic                  stopped_early,
  output logic                  master_abort
);

  localparam int CBE_W  = DATA_W / 8;
  localparam int ADDR_W = 2 * DATA_W;

  busx_state_e state;

  // captured request
  logic [ADDR_W-1:0] addr_q;
  logic [CBE_W-1:0]  cmd_q;
  logic              wr_q;
  logic [BEAT_W-1:0] len_q;

  logic accept, in_adr, in_data, irdy, xfer, tstop, finish;
  logic dual, beat_final, timeout;
  logic [DATA_W-1:0] adr_word;
  logic [CBE_W-1:0]  adr_cbe;

  logic stopped_q, stopped_d, abort_q, abort_d;
  logic rdv_q, rdv_d;
  logic [DATA_W-1:0] rdd_q;

  assign accept  = (state == ST_IDLE) && req_start;
  assign in_adr  = (state == ST_ADR1) || (state == ST_ADR2);
  assign in_data = (state == ST_DATA);
  assign irdy    = in_data && !loc_hold;
  assign xfer    = irdy && trdy_i && devsel_i;
  assign tstop   = in_data && stop_i && devsel_i;
  assign finish  = beat_final || tstop || timeout;

  busx_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .gnt    (bus_gnt),
    .dual   (dual),
    .finish (finish),
    .state  (state)
  );

  busx_addr_phase #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_addr (
    .addr     (addr_q),
    .cmd      (cmd_q),
    .hi_cycle (state == ST_ADR2),
    .dual     (dual),
    .ad       (adr_word),
    .cbe      (adr_cbe)
  );

  busx_beat_track #(.BEAT_W(BEAT_W), .ABORT_CLKS(ABORT_CLKS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .active     (in_data),
    .xfer       (xfer),
    .devsel     (devsel_i),
    .len_m1     (len_q),
    .count      (beat_count),
    .beat_final (beat_final),
    .timeout    (timeout)
  );

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      wr_q   <= 1'b0;
      len_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      cmd_q  <= req_cmd;
      wr_q   <= req_write;
      len_q  <= req_beats_m1;
    end
  end

  // end-of-transaction status
  always_comb begin
    stopped_d = stopped_q;
    abort_d   = abort_q;
    if (accept) begin
      stopped_d = 1'b0;
      abort_d   = 1'b0;
    end else begin
      if (tstop && !beat_final) stopped_d = 1'b1;
      if (timeout)              abort_d   = 1'b1;
    end
    rdv_d = xfer && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
      abort_q   <= 1'b0;
      rdv_q     <= 1'b0;
    end else begin
      stopped_q <= stopped_d;
      abort_q   <= abort_d;
      rdv_q     <= rdv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdd_q <= '0;
    else if (rdv_d) rdd_q <= ad_i;
  end

  // bus-side outputs
  always_comb begin
    ad_o  = '0;
    cbe_o = '0;
    ad_oe = 1'b0;
    if (in_adr) begin
      ad_o  = adr_word;
      cbe_o = adr_cbe;
      ad_oe = 1'b1;
    end else if (in_data) begin
      cbe_o = beat_mask;
      ad_oe = wr_q;
      if (wr_q) ad_o = beat_data;
    end
  end

  assign bus_req       = (state == ST_REQ);
  assign frame_o       = in_adr || in_data;
  assign irdy_o        = irdy;
  assign done          = (state == ST_END);
  assign stopped_early = stopped_q;
  assign master_abort  = abort_q;
  assign rd_valid      = rdv_q;
  assign rd_data       = rdd_q;

endmodule

// File: rtl/busx_initiator_chk.sv
module busx_initiator_chk #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              frame_o,
  input logic              irdy_o,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe,
  input logic [CBE_W-1:0]  cbe_o,
  input logic              trdy_i,
  input logic              devsel_i,
  input logic              done,
  input logic              rd_valid
);

  localparam logic [CBE_W-1:0] LONG_CODE = CBE_W'(4'b1101);

  // R1
  frame_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> $past(bus_gnt));

  // R1
  req_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !frame_o);

  // R3
  long_addr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_o) && cbe_o == LONG_CODE) |=> (frame_o && ad_o != '0 && cbe_o != LONG_CODE));

  // R5
  read_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(irdy_o && trdy_i && devsel_i && !ad_oe));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !frame_o && $past(frame_o));

  // R10
  irdy_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irdy_o |-> frame_o);

endmodule

bind busx_initiator busx_initiator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .frame_o  (frame_o),
  .irdy_o   (irdy_o),
  .ad_o     (ad_o),
  .ad_oe    (ad_oe),
  .cbe_o    (cbe_o),
  .trdy_i   (trdy_i),
  .devsel_i (devsel_i),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/busx_initiator_bench.sv
`timescale 1ns/1ps
module busx_initiator_bench;

  localparam int BW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_start, req_write, loc_hold, bus_gnt;
  logic [63:0]   req_addr;
  logic [3:0]    req_cmd, beat_mask;
  logic [BW-1:0] req_beats_m1;
  logic [31:0]   beat_data, ad_i;
  logic          devsel_i, trdy_i, stop_i;
  logic          bus_req, frame_o, irdy_o, ad_oe, rd_valid, done, stopped_early, master_abort;
  logic [31:0]   ad_o, rd_data;
  logic [3:0]    cbe_o;
  logic [BW:0]   beat_count;

  busx_initiator #(.DATA_W(32), .BEAT_W(BW), .ABORT_CLKS(4)) u_busx_initiator (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_write(req_write), .req_beats_m1(req_beats_m1),
    .loc_hold(loc_hold), .beat_data(beat_data), .beat_mask(beat_mask),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .frame_o(frame_o), .irdy_o(irdy_o),
    .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .ad_i(ad_i), .devsel_i(devsel_i),
    .trdy_i(trdy_i), .stop_i(stop_i), .beat_count(beat_count), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .stopped_early(stopped_early),
    .master_abort(master_abort)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [16];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wdat(input int b);
    return 32'hC3000000 ^ (32'(b) * 32'h01030507);
  endfunction
  function automatic logic [3:0] wmask(input int b);
    return 4'((b * 7 + 1) % 16);
  endfunction
  function automatic logic [31:0] rword(input int b);
    return 32'h1E000000 + 32'(b) * 32'h00110011;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  task automatic run(input logic [63:0] addr, input bit wr, input int lm1, input int dly,
                     input int tw, input bit hold_en, input int stop_b, input bit stop_dat,
                     input bit poke);
    int exp_beats, n, bb, wc;
    bit exp_abort, exp_early, dual, pend;
    logic [31:0] pend_exp, e;
    logic [3:0] cmd;
    cmd  = wr ? 4'h7 : 4'h6;
    dual = (addr[63:32] != 32'h0);
    exp_abort = (dly >= 4);
    if (exp_abort) exp_beats = 0;
    else if (stop_b >= 0 && stop_b <= lm1) exp_beats = stop_b + (stop_dat ? 1 : 0);
    else exp_beats = lm1 + 1;
    exp_early = !exp_abort && (exp_beats < lm1 + 1);
    for (int i = 0; i < 16; i++) mem[i] = 32'h5A5A5A5A;

    @(negedge clk);
    req_addr = addr; req_cmd = cmd; req_write = wr; req_beats_m1 = BW'(lm1);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(bus_req && !frame_o, "R1 request raised, no frame", {bus_req, frame_o}, 2'b10);
    for (int g = 0; g < (lm1 % 3); g++) begin
      @(negedge clk);
      chk(bus_req && !frame_o, "R1 no frame before grant", {bus_req, frame_o}, 2'b10);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    if (dual)
      chk(frame_o && ad_oe && ad_o == addr[31:0] && cbe_o == 4'b1101, "R3 first address cycle",
          {cbe_o, ad_o}, {4'b1101, addr[31:0]});
    else
      chk(frame_o && ad_oe && ad_o == addr[31:0] && cbe_o == cmd, "R2 single address cycle",
          {cbe_o, ad_o}, {cmd, addr[31:0]});
    if (poke) begin
      req_start = 1'b1; req_addr = ~addr; req_cmd = ~cmd;
    end
    @(negedge clk);
    req_start = 1'b0;
    if (dual) begin
      chk(frame_o && ad_o == addr[63:32] && cbe_o == cmd, "R3 second address cycle",
          {cbe_o, ad_o}, {cmd, addr[63:32]});
      @(negedge clk);
    end

    n = 0; bb = 0; wc = 0; pend = 1'b0; pend_exp = '0;
    while (frame_o) begin
      if (pend) chk(rd_valid && rd_data == pend_exp, "R4 read word", rd_data, pend_exp);
      pend = 1'b0;
      loc_hold  = hold_en && (n % 3 == 1);
      devsel_i  = (n >= dly);
      trdy_i    = 1'b0;
      stop_i    = 1'b0;
      beat_data = wdat(int'(beat_count));
      beat_mask = wmask(int'(beat_count));
      ad_i      = rword(bb);
      #1;
      chk(irdy_o == !loc_hold, "R5 irdy follows hold", irdy_o, !loc_hold);
      if (devsel_i) begin
        if (bb == stop_b && !stop_dat) stop_i = 1'b1;
        else begin
          if (wc >= tw) trdy_i = 1'b1;
          else wc++;
          if (trdy_i && irdy_o && bb == stop_b && stop_dat) stop_i = 1'b1;
        end
      end
      #1;
      if (irdy_o && trdy_i && devsel_i) begin
        if (wr) begin
          chk(ad_oe && ad_o == wdat(bb) && cbe_o == wmask(bb), "R4 write beat",
              {cbe_o, ad_o}, {wmask(bb), wdat(bb)});
          mem[bb % 16] = merge(mem[bb % 16], ad_o, cbe_o);
        end else begin
          chk(!ad_oe, "R4 read direction", ad_oe, 1'b0);
          pend = 1'b1; pend_exp = rword(bb);
        end
        bb++; wc = 0;
      end
      @(negedge clk);
      n++;
      if (n > 80) begin
        chk(1'b0, "R6 transaction never ended", n, 0);
        break;
      end
    end
    loc_hold = 1'b0; devsel_i = 1'b0; trdy_i = 1'b0; stop_i = 1'b0;
    if (pend) chk(rd_valid && rd_data == pend_exp, "R4 read word", rd_data, pend_exp);
    chk(done, "R6 done pulse", done, 1);
    chk(int'(beat_count) == exp_beats && bb == exp_beats, "R6 R7 beat total", beat_count, exp_beats);
    chk(stopped_early == exp_early, "R7 stopped early flag", stopped_early, exp_early);
    chk(master_abort == exp_abort, "R8 master abort flag", master_abort, exp_abort);
    if (exp_abort) chk(n == 4, "R8 abort window", n, 4);
    if (wr)
      for (int i = 0; i < 16; i++) begin
        e = (i < exp_beats) ? merge(32'h5A5A5A5A, wdat(i), wmask(i)) : 32'h5A5A5A5A;
        chk(mem[i] == e, "R4 masked target image", mem[i], e);
      end
    @(negedge clk);
    chk(!done && !bus_req && !frame_o, "R9 idle after done", {done, bus_req, frame_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lens [4];
    logic [63:0] addrs [3];
    lens[0] = 0; lens[1] = 1; lens[2] = 3; lens[3] = 15;
    addrs[0] = 64'h0000_0000_1000_0040;
    addrs[1] = 64'h0000_0001_2000_0080;
    addrs[2] = 64'h8000_0000_0000_0000;
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; loc_hold = 1'b0; bus_gnt = 1'b0;
    req_addr = '0; req_cmd = '0; beat_mask = '0; req_beats_m1 = '0;
    beat_data = '0; ad_i = '0; devsel_i = 1'b0; trdy_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !frame_o && !irdy_o && !ad_oe && !done, "R10 reset outputs",
        {bus_req, frame_o, irdy_o, ad_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main sweep: address form, direction, length, claim delay, wait states, hold
    for (int a = 0; a < 2; a++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++)
          for (int d = 0; d < 2; d++)
            for (int t = 0; t < 2; t++)
              for (int h = 0; h < 2; h++)
                run(addrs[a], w[0], lens[l], 2 * d, t, h[0], -1, 1'b0, 1'b0);

    // R7 stop at each beat of a four-beat burst, with and without data
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int sd = 0; sd < 2; sd++)
          run(addrs[w], w[0], 3, 1, 1, 1'b1, s, sd[0], 1'b0);
    run(addrs[0], 1'b1, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0);

    // R8 claim at the edge of the window and past it
    for (int w = 0; w < 2; w++) begin
      run(addrs[2], w[0], 2, 3, 0, 1'b0, -1, 1'b0, 1'b0);
      run(addrs[2], w[0], 2, 4, 0, 1'b0, -1, 1'b0, 1'b0);
      run(addrs[0], w[0], 2, 7, 0, 1'b0, -1, 1'b0, 1'b0);
    end

    // R9 start pulses while busy
    run(addrs[1], 1'b1, 3, 0, 0, 1'b0, -1, 1'b0, 1'b1);
    run(addrs[0], 1'b0, 3, 1, 1, 1'b0, -1, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule